// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Command Strobe

This block is a timer/counter that runs a triangle count: up from zero to a period limit, then back down to zero, one step per prescaled tick. Each compare channel drives a PWM output that is high while the count is above the channel's compare value. The result is a center-aligned waveform whose period is twice the period limit in ticks. The resolution in bits is log2 of the period limit plus one.

The period limit and the compare values are written into shadow buffers. The active registers take the buffered values only at an update point. An update point happens naturally when a tick arrives with the count at zero. A two-bit command strobe can also force one immediately. The same strobe can restart the count, or return every register to its reset value. The return to reset takes effect only while the clock select is off.

Sticky flags record bottom-of-count events and compare matches, and together they raise one interrupt request. A capture-mode bit limits what a forced update touches. The capture logic itself is not part of this block.

Top module: `dspwm_timer`

## Requirements
- R1: After reset the count is 0 and counts up. The active and buffered period are all ones. The active and buffered compare values are 0. All flags, the interrupt request and all PWM outputs are 0.
- R2: On each tick the count steps by one between 0 and the active period. The sequence for period P is 0,1..P,P-1..1,0,1..., so the extremes each last one tick and the triangle repeats every 2*P ticks.
- R3: Clock select 0 is OFF and the count holds. A select value s from 1 to 7 gives one tick every 2^(s-1) clock cycles.
- R4: Buffer writes leave the active period and compare values unchanged until an update point. The natural update point is a tick taken while the count is 0; the active registers load on that clock edge.
- R5: Command 01 (force update) loads the active period and all active compare values from their buffers on the next clock edge, whatever the count.
- R6: While capture mode is 1, a forced update loads only the period. The active compare values keep their old contents.
- R7: Command 10 (restart) sets the count to 0 and the direction to up on the next edge. Counting then resumes upward.
- R8: Command 11 (hard reset) returns every register, including buffers and flags, to its R1 value, but only while clock select is 0. With any other clock select it has no effect.
- R9: The PWM output of a channel is 1 exactly while the count is greater than that channel's active compare value. It therefore rises on the upward crossing and falls on the downward crossing.
- R10: The overflow flag sets on each natural update point. Compare flag i sets on a tick taken while the count equals compare value i. Flags stay set until their clear bit is pulsed: bit 0 clears overflow, bit 1+i clears compare flag i; a set event wins. The interrupt request is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | SEL_W | Prescaler select, 0 = OFF |
| capture_mode_i | input | 1 | Capture mode, restricts forced update to period |
| cmd_i | input | 2 | One-cycle command: 00 none, 01 update, 10 restart, 11 hard reset |
| per_wr_i | input | 1 | Write strobe for period buffer |
| per_wdata_i | input | W | Period buffer write data |
| cmp_wr_i | input | NUM_CC | Write strobes for compare buffers, one per channel |
| cmp_wdata_i | input | W | Compare buffer write data |
| flag_clr_i | input | NUM_CC+1 | Flag clear pulses, bit 0 overflow, bit 1+i compare i |
| cnt_o | output | W | Current count |
| per_o | output | W | Active period |
| cmp_o | output | NUM_CC*W | Active compare values, channel i at bits [i*W +: W] |
| pwm_o | output | NUM_CC | PWM outputs |
| ovf_flag_o | output | 1 | Overflow (bottom) flag |
| cmp_flag_o | output | NUM_CC | Compare match flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The count is traced over several whole periods with a divide-by-one tick, which separates a correct turn-around at both ends from off-by-one errors at the top or the bottom. A divide-by-four select and an OFF select show the tick rate and that the count holds. Buffer writes made mid-ramp, followed by natural and forced updates with capture mode low and high, show when and what the active registers take. Two compare values over one full period check the PWM duty and the match flags, and hard reset is issued with the clock running and with it off to show the gate.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_UPDATE  = 2'b01,
    CMD_RESTART = 2'b10,
    CMD_HRST    = 2'b11
  } tc_cmd_e;
endpackage

// File: rtl/dspwm_presc.sv
module dspwm_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hrst_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << SEL_W) - 2;

  logic [PRE_W-1:0] pre_q, mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(sel_i) - 1) mask[i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (sel_i == '0 || hrst_i)   pre_q <= '0;
    else                              pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
  end

  assign tick_o = (sel_i != '0) && ((pre_q & mask) == mask);

  a_r3_off_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> !tick_o);
endmodule

// File: rtl/dspwm_cnt.sv
module dspwm_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic         hrst_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_up_o,
  output logic         bottom_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (hrst_i || restart_i) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tick_i) begin
      if (dir_q) begin
        if (cnt_q >= per_i) begin
          dir_q <= 1'b0;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        dir_q <= 1'b1;
        cnt_q <= (per_i == '0) ? '0 : ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign bottom_o = tick_i && (cnt_q == '0) && !restart_i && !hrst_i;
  assign cnt_o    = cnt_q;
  assign dir_up_o = dir_q;

  a_r7_restart_to_zero_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && dir_q));
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && !hrst_i && per_i != '0)
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i && !hrst_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dspwm_ch.sv
module dspwm_ch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hrst_i,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         dir_up_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  input  logic         clr_i,
  output logic [W-1:0] cmp_o,
  output logic         pwm_o,
  output logic         flag_o
);
  logic [W-1:0] buf_q, cmp_q;
  logic         flag_q, match;

  assign match = tick_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else if (hrst_i) begin
      buf_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i)   buf_q <= wdata_i;
      if (load_i) cmp_q <= buf_q;
      flag_q <= match || (flag_q && !clr_i);
    end
  end

  assign pwm_o  = cnt_i > cmp_q;
  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;

  a_r9_pwm_rises_counting_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_o) && $stable(cmp_q)) |-> dir_up_i);
  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i && !hrst_i) |=> flag_q);
endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
  import dspwm_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CC = 2,
  parameter int SEL_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    clk_sel_i,
  input  logic                capture_mode_i,
  input  logic [1:0]          cmd_i,
  input  logic                per_wr_i,
  input  logic [W-1:0]        per_wdata_i,
  input  logic [NUM_CC-1:0]   cmp_wr_i,
  input  logic [W-1:0]        cmp_wdata_i,
  input  logic [NUM_CC:0]     flag_clr_i,
  output logic [W-1:0]        cnt_o,
  output logic [W-1:0]        per_o,
  output logic [NUM_CC*W-1:0] cmp_o,
  output logic [NUM_CC-1:0]   pwm_o,
  output logic                ovf_flag_o,
  output logic [NUM_CC-1:0]   cmp_flag_o,
  output logic                irq_o
);
  logic         tick, bottom, dir_up;
  logic         force_upd, restart, hrst, cmp_load;
  logic [W-1:0] per_buf_q, per_q;
  logic         ovf_q;

  assign force_upd = (cmd_i == CMD_UPDATE);
  assign restart   = (cmd_i == CMD_RESTART);
  // hard reset only honoured while the clock is gated off
  assign hrst      = (cmd_i == CMD_HRST) && (clk_sel_i == '0);
  assign cmp_load  = bottom || (force_upd && !capture_mode_i);

  dspwm_presc #(.SEL_W(SEL_W)) u_presc (
    .clk_i, .rst_ni, .sel_i(clk_sel_i), .hrst_i(hrst), .tick_o(tick)
  );

  dspwm_cnt #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(restart), .hrst_i(hrst),
    .per_i(per_q), .cnt_o, .dir_up_o(dir_up), .bottom_o(bottom)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_q <= '1;
      per_q     <= '1;
      ovf_q     <= 1'b0;
    end else if (hrst) begin
      per_buf_q <= '1;
      per_q     <= '1;
      ovf_q     <= 1'b0;
    end else begin
      if (per_wr_i)            per_buf_q <= per_wdata_i;
      if (bottom || force_upd) per_q     <= per_buf_q;
      ovf_q <= bottom || (ovf_q && !flag_clr_i[0]);
    end
  end

  for (genvar i = 0; i < NUM_CC; i++) begin : g_ch
    dspwm_ch #(.W(W)) u_ch (
      .clk_i, .rst_ni, .hrst_i(hrst), .tick_i(tick), .cnt_i(cnt_o),
      .dir_up_i(dir_up), .wr_i(cmp_wr_i[i]), .wdata_i(cmp_wdata_i),
      .load_i(cmp_load), .clr_i(flag_clr_i[i+1]),
      .cmp_o(cmp_o[i*W +: W]), .pwm_o(pwm_o[i]), .flag_o(cmp_flag_o[i])
    );
  end

  assign per_o      = per_q;
  assign ovf_flag_o = ovf_q;
  assign irq_o      = ovf_q || (|cmp_flag_o);

  a_r5_force_update_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_UPDATE) |=> (per_q == $past(per_buf_q)));
  a_r6_capture_keeps_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_UPDATE && capture_mode_i && !bottom) |=> $stable(cmp_o));
  a_r8_hrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_HRST && clk_sel_i == '0) |=> (per_q == '1 && cnt_o == '0 && !irq_o));
  a_r8_hrst_ignored_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_HRST && clk_sel_i != '0 && !bottom) |=> $stable(per_q));
endmodule

// File: tb/dspwm_timer_tb.sv
`timescale 1ns/1ps
module dspwm_timer_tb;
  localparam int W = 16;
  localparam int NC = 2;

  logic          clk = 0, rst_n = 0;
  logic [2:0]    clk_sel = 0;
  logic          capture = 0;
  logic [1:0]    cmd = 0;
  logic          per_wr = 0;
  logic [W-1:0]  per_wdata = 0;
  logic [NC-1:0] cmp_wr = 0;
  logic [W-1:0]  cmp_wdata = 0;
  logic [NC:0]   flag_clr = 0;
  logic [W-1:0]  cnt, per;
  logic [NC*W-1:0] cmp;
  logic [NC-1:0] pwm, cmp_flag;
  logic          ovf, irq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dspwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .capture_mode_i(capture),
    .cmd_i(cmd), .per_wr_i(per_wr), .per_wdata_i(per_wdata), .cmp_wr_i(cmp_wr),
    .cmp_wdata_i(cmp_wdata), .flag_clr_i(flag_clr), .cnt_o(cnt), .per_o(per),
    .cmp_o(cmp), .pwm_o(pwm), .ovf_flag_o(ovf), .cmp_flag_o(cmp_flag), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tri_val(int k, int p);
    int m = k % (2 * p);
    return (m <= p) ? m : 2 * p - m;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // clock off, load buffers, force update, restart, clear flags
  task automatic setup(int p, int c0, int c1);
    @(negedge clk); clk_sel = 0; per_wr = 1; per_wdata = W'(p); cmp_wr = 2'b01; cmp_wdata = W'(c0);
    @(negedge clk); per_wr = 0; cmp_wr = 2'b10; cmp_wdata = W'(c1);
    @(negedge clk); cmp_wr = 0; cmd = 2'b01;
    @(negedge clk); cmd = 2'b10; flag_clr = '1;
    @(negedge clk); cmd = 2'b00; flag_clr = '0;
  endtask

  task automatic t_reset();
    check("R1 cnt", cnt, 0);
    check("R1 per", per, 32'hFFFF);
    check("R1 cmp", cmp, 0);
    check("R1 flags", {ovf, cmp_flag, irq}, 0);
    check("R1 pwm", pwm, 0);
  endtask

  task automatic t_triangle();
    int bad = 0;
    setup(4, 1, 2);
    clk_sel = 1;
    for (int k = 1; k <= 20; k++) begin
      step(1);
      if (cnt !== W'(tri_val(k, 4))) begin
        bad++;
        check("R2 triangle count", cnt, tri_val(k, 4));
      end
    end
    check("R2 triangle mismatches", bad, 0);
  endtask

  task automatic t_presc();
    setup(4, 1, 2);
    clk_sel = 3;
    step(7);
    check("R3 div4 after 7 clocks", cnt, 1);
    step(1);
    check("R3 div4 after 8 clocks", cnt, 2);
    clk_sel = 0;
    step(5);
    check("R3 off holds count", cnt, 2);
  endtask

  task automatic t_buffer();
    setup(4, 1, 2);
    clk_sel = 1;
    step(2);
    per_wr = 1; per_wdata = 6; cmp_wr = 2'b01; cmp_wdata = 3;
    step(1);
    per_wr = 0; cmp_wr = 0;
    check("R4 period unchanged after write", per, 4);
    check("R4 compare unchanged after write", cmp[15:0], 1);
    step(5);
    check("R4 count at bottom", cnt, 0);
    check("R4 period held until bottom tick", per, 4);
    step(1);
    check("R4 period loaded at bottom", per, 6);
    check("R4 compare loaded at bottom", cmp[15:0], 3);
    check("R10 overflow flag at bottom", ovf, 1);
    step(5);
    check("R4 new period top", cnt, 6);
  endtask

  task automatic t_force();
    setup(4, 1, 2);
    clk_sel = 1;
    step(2);
    per_wr = 1; per_wdata = 7; cmp_wr = 2'b01; cmp_wdata = 5;
    step(1);
    per_wr = 0; cmp_wr = 0; cmd = 2'b01;
    step(1);
    cmd = 0;
    check("R5 forced period", per, 7);
    check("R5 forced compare", cmp[15:0], 5);
    check("R5 count mid ramp", cnt, 4);
    clk_sel = 0; capture = 1;
    per_wr = 1; per_wdata = 9; cmp_wr = 2'b01; cmp_wdata = 8;
    step(1);
    per_wr = 0; cmp_wr = 0; cmd = 2'b01;
    step(1);
    cmd = 0;
    check("R6 capture mode period loads", per, 9);
    check("R6 capture mode compare kept", cmp[15:0], 5);
    capture = 0;
  endtask

  task automatic t_restart();
    setup(4, 1, 2);
    clk_sel = 1;
    step(6);
    check("R7 counting down before restart", cnt, 2);
    cmd = 2'b10;
    step(1);
    cmd = 0;
    check("R7 restart zero", cnt, 0);
    step(1);
    check("R7 resumes upward 1", cnt, 1);
    step(1);
    check("R7 resumes upward 2", cnt, 2);
  endtask

  task automatic t_hrst();
    setup(5, 2, 3);
    clk_sel = 1;
    step(3);
    cmd = 2'b11;
    step(1);
    cmd = 0;
    check("R8 ignored while running cnt", cnt, 4);
    check("R8 ignored while running per", per, 5);
    check("R8 ignored while running ovf", ovf, 1);
    clk_sel = 0;
    step(1);
    cmd = 2'b11;
    step(1);
    cmd = 0;
    check("R8 hard reset cnt", cnt, 0);
    check("R8 hard reset per", per, 32'hFFFF);
    check("R8 hard reset cmp", cmp, 0);
    check("R8 hard reset flags", {ovf, cmp_flag, irq}, 0);
    cmd = 2'b01;
    step(1);
    cmd = 0;
    check("R8 buffers reset per", per, 32'hFFFF);
    check("R8 buffers reset cmp", cmp, 0);
  endtask

  task automatic t_pwm();
    int hi0 = 0, hi1 = 0, bad = 0;
    setup(4, 1, 3);
    clk_sel = 1;
    for (int k = 1; k <= 8; k++) begin
      step(1);
      if (pwm[0] !== (tri_val(k, 4) > 1)) bad++;
      if (pwm[1] !== (tri_val(k, 4) > 3)) bad++;
      hi0 += int'(pwm[0]);
      hi1 += int'(pwm[1]);
    end
    check("R9 pwm level mismatches", bad, 0);
    check("R9 duty ch0", hi0, 5);
    check("R9 duty ch1", hi1, 1);
  endtask

  task automatic t_flags();
    setup(4, 2, 3);
    clk_sel = 1;
    step(1);
    check("R10 overflow set", ovf, 1);
    check("R10 irq with overflow", irq, 1);
    check("R10 no compare match yet", cmp_flag, 0);
    step(2);
    check("R10 compare ch0 match", cmp_flag, 2'b01);
    step(1);
    check("R10 compare ch1 match", cmp_flag, 2'b11);
    clk_sel = 0; flag_clr = 3'b001;
    step(1);
    flag_clr = 0;
    check("R10 overflow cleared", ovf, 0);
    check("R10 compare flags kept", cmp_flag, 2'b11);
    check("R10 irq from compare", irq, 1);
    flag_clr = 3'b110;
    step(1);
    flag_clr = 0;
    check("R10 compare cleared", cmp_flag, 0);
    check("R10 irq low", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_triangle();
    t_presc();
    t_buffer();
    t_force();
    t_restart();
    t_hrst();
    t_pwm();
    t_flags();
    finish_run();
  end
endmodule